// File: doc/BRIEF.md
# Packet Memory Pointer and Data Port

This block gives a host processor byte- and word-wide access to packet buffers held in a shared SRAM. The host first writes a 16-bit pointer word. That word holds the byte offset inside a packet, a direction flag, an auto-advance flag and an area flag. The area flag picks either the packet number the host loaded into its own transmit packet register or the packet number at the head of the receive queue, which arrives on an input. After that, the host moves packet bytes by reading or writing a single data register. When auto-advance is on, the offset steps forward after every data access.

The memory port is a simple synchronous SRAM interface. Memory is organised as 16-bit words, and read data appears one cycle after the read strobe. The packet number forms the upper address bits and the word offset forms the lower bits. In read mode the block keeps the word at the current offset fetched ahead of time, so the host can read on every cycle without a wait state.

Received packets begin with a status word, followed by a byte-count word. Together with the trailing control bytes, the framing around the payload is six bytes. While the host reads this header in word mode, the block captures it and presents three results: the payload length, an error summary and a multicast flag.

Top module: `pdp_port`

## Requirements
- R1: After reset the pointer word and the transmit packet number read as 0. The pointer word is laid out as follows: bit 15 selects the receive area, bit 14 enables auto-advance, bit 13 selects read direction and bits 10:0 hold the byte offset. Bits 12:11 always read 0. The host register select codes are 0 for pointer, 1 for transmit packet number, 2 for data and 3 for an unused register that reads 0.
- R2: Every memory access uses word address {packet, offset[10:1]}. The packet is `rx_head_pkt` when pointer bit 15 is 1 and the transmit packet register when bit 15 is 0.
- R3: With bit 14 set, each accepted data access advances the offset by 1 for a byte access and by 2 for a word access, wrapping modulo 2048. With bit 14 clear, the offset does not change.
- R4: A word write drives `mem_be`=11 with the full host word. A byte write puts `host_wdata[7:0]` into the low lane (`mem_be`=01) when offset bit 0 is 0 and into the high lane (`mem_be`=10) when it is 1. A byte read returns the byte at the current offset in `host_rdata[7:0]`, with the upper byte 0.
- R5: In read mode, a data read returns the word at the current offset in the same cycle. This holds from the cycle after the pointer write onward, and reads on consecutive cycles return consecutive data with no idle cycle. A memory read and a memory write never occur together.
- R6: A data write while bit 13 is set causes no memory write and does not move the offset. A data read while bit 13 is clear returns 0 and does not move the offset.
- R7: Word reads of the receive area capture the status word at offset 0 and the count word at offset 2. One cycle later, `rx_len` equals (count[10:0] − 6 + status[12]) modulo 2048.
- R8: One cycle after the status capture, `rx_err` is the OR of status bits 15, 13, 11 and 10, and `rx_mcast` equals status bit 0.
- R9: Writing the transmit packet number while the pointer is in read mode on the transmit area refetches the data. The next data read returns the word from the new packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select: 0 pointer, 1 tx packet, 2 data, 3 unused |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_byte | input | 1 | Data access is a byte access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, same cycle |
| rx_head_pkt | input | PN_W | Packet number at the head of the receive queue |
| mem_addr | output | PN_W+OFS_W-1 | Packet memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Memory byte lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |
| rx_len | output | OFS_W | Receive payload length from captured header |
| rx_err | output | 1 | Receive error summary from captured status |
| rx_mcast | output | 1 | Receive multicast flag from captured status |

## Verification
Directed cases come first. Word and byte writes with odd and even start offsets separate the lane selection from the advance step. Runs with auto-advance on and off show whether the offset moves only when it should. The offset wrap at 2047 checks the modulo boundary. Back-to-back reads right after a pointer write, and right after a packet number change, show whether the prefetch is one cycle late. Header words are tried with the odd-length bit and with each error bit set on its own. Random runs then mix packets, start offsets, widths and lengths, and compare every read word and final pointer against a bench model.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int WORD_W    = 16;
  localparam int BIT_RCV   = 15;
  localparam int BIT_AINC  = 14;
  localparam int BIT_RD    = 13;
  localparam int HDR_BYTES = 6;
  localparam int ST_MC     = 0;
  localparam int ST_SHORT  = 10;
  localparam int ST_LONG   = 11;
  localparam int ST_ODD    = 12;
  localparam int ST_CRC    = 13;
  localparam int ST_ALGN   = 15;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_PKT  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic rcv;
    logic ainc;
    logic rd;
  } ptr_mode_t;
endpackage

// File: rtl/pdp_rst_sync.sv
module pdp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
  import pdp_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [WORD_W-1:0]     load_word,
  input  logic                  adv_en,
  input  logic                  adv_byte,
  output ptr_mode_t             mode_q,
  output logic [OFS_W-1:0]      ofs_q,
  output ptr_mode_t             mode_d,
  output logic [OFS_W-1:0]      ofs_d
);
  localparam logic [OFS_W-1:0] STEP_B = OFS_W'(1);
  localparam logic [OFS_W-1:0] STEP_W = OFS_W'(2);

  logic unused_load_bits;
  assign unused_load_bits = ^load_word;

  always_comb begin
    mode_d = mode_q;
    ofs_d  = ofs_q;
    if (load) begin
      mode_d.rcv  = load_word[BIT_RCV];
      mode_d.ainc = load_word[BIT_AINC];
      mode_d.rd   = load_word[BIT_RD];
      ofs_d       = load_word[OFS_W-1:0];
    end else if (adv_en) begin
      ofs_d = ofs_q + (adv_byte ? STEP_B : STEP_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ofs_q  <= '0;
    end else if (load || adv_en) begin
      mode_q <= mode_d;
      ofs_q  <= ofs_d;
    end
  end
endmodule

// File: rtl/pdp_prefetch.sv
module pdp_prefetch
  import pdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] word
);
  logic              pend_q;
  logic [WORD_W-1:0] buf_q;
  logic [WORD_W-1:0] buf_d;

  always_comb begin
    buf_d = pend_q ? mem_rdata : buf_q;
    word  = buf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      pend_q <= fetch;
      if (pend_q) buf_q <= buf_d;
    end
  end
endmodule

// File: rtl/pdp_hdr_decode.sv
module pdp_hdr_decode
  import pdp_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_status,
  input  logic              cap_count,
  input  logic [WORD_W-1:0] word,
  output logic [OFS_W-1:0]  rx_len,
  output logic              rx_err,
  output logic              rx_mcast
);
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] count_q;
  logic              unused_hdr_bits;

  assign unused_hdr_bits = ^{status_q, count_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      count_q  <= '0;
    end else begin
      if (cap_status) status_q <= word;
      if (cap_count)  count_q  <= word;
    end
  end

  always_comb begin
    rx_len   = count_q[OFS_W-1:0] - OFS_W'(HDR_BYTES) + OFS_W'(status_q[ST_ODD]);
    rx_err   = status_q[ST_ALGN] | status_q[ST_CRC] | status_q[ST_LONG] | status_q[ST_SHORT];
    rx_mcast = status_q[ST_MC];
  end
endmodule

// File: rtl/pdp_port.sv
module pdp_port
  import pdp_pkg::*;
#(
  parameter int PN_W  = 2,
  parameter int OFS_W = 11,
  localparam int AW   = PN_W + OFS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_byte,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic [PN_W-1:0]   rx_head_pkt,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic [OFS_W-1:0]  rx_len,
  output logic              rx_err,
  output logic              rx_mcast
);
  logic             rst_n_s;
  reg_sel_e         sel;
  logic             ptr_we, pkt_we, dwr, drd, adv_en, fetch;
  ptr_mode_t        mode_q, mode_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [PN_W-1:0]  pkt_q, pkt_d;
  logic [PN_W-1:0]  cur_pkt, nxt_pkt;
  logic [15:0]      pf_word;
  logic [7:0]       lane_byte;
  logic             hdr_cap, cap_status, cap_count;

  pdp_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  always_comb begin
    sel    = reg_sel_e'(host_sel);
    ptr_we = host_wr && (sel == SEL_PTR);
    pkt_we = host_wr && (sel == SEL_PKT);
    dwr    = host_wr && (sel == SEL_DATA) && !mode_q.rd;
    drd    = host_rd && !host_wr && (sel == SEL_DATA) && mode_q.rd;
    adv_en = (dwr || drd) && mode_q.ainc;
    pkt_d  = pkt_we ? host_wdata[PN_W-1:0] : pkt_q;
    fetch  = (ptr_we && host_wdata[BIT_RD])
          || (pkt_we && mode_q.rd && !mode_q.rcv)
          || (drd && mode_q.ainc);
  end

  pdp_ptr_reg #(.OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n_s),
    .load(ptr_we), .load_word(host_wdata),
    .adv_en(adv_en), .adv_byte(host_byte),
    .mode_q(mode_q), .ofs_q(ofs_q),
    .mode_d(mode_d), .ofs_d(ofs_d)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    pkt_q <= '0;
    else if (pkt_we) pkt_q <= pkt_d;
  end

  // address generation: writes use the present pointer, fetches the next one
  always_comb begin
    cur_pkt   = mode_q.rcv ? rx_head_pkt : pkt_q;
    nxt_pkt   = mode_d.rcv ? rx_head_pkt : pkt_d;
    mem_addr  = dwr ? {cur_pkt, ofs_q[OFS_W-1:1]} : {nxt_pkt, ofs_d[OFS_W-1:1]};
    mem_we    = dwr;
    mem_re    = fetch;
    mem_be    = host_byte ? (ofs_q[0] ? 2'b10 : 2'b01) : 2'b11;
    mem_wdata = host_byte ? {2{host_wdata[7:0]}} : host_wdata;
  end

  pdp_prefetch u_pf (
    .clk(clk), .rst_n(rst_n_s), .fetch(fetch),
    .mem_rdata(mem_rdata), .word(pf_word)
  );

  always_comb begin
    lane_byte = ofs_q[0] ? pf_word[15:8] : pf_word[7:0];
    unique case (sel)
      SEL_PTR:  host_rdata = {mode_q, 13'b0} | 16'(ofs_q);
      SEL_PKT:  host_rdata = 16'(pkt_q);
      SEL_DATA: host_rdata = !mode_q.rd ? 16'h0000 :
                             (host_byte ? {8'h00, lane_byte} : pf_word);
      default:  host_rdata = 16'h0000;
    endcase
  end

  always_comb begin
    hdr_cap    = drd && !host_byte && mode_q.rcv;
    cap_status = hdr_cap && (ofs_q[OFS_W-1:1] == '0);
    cap_count  = hdr_cap && (ofs_q[OFS_W-1:1] == (OFS_W-1)'(1));
  end

  pdp_hdr_decode #(.OFS_W(OFS_W)) u_hdr (
    .clk(clk), .rst_n(rst_n_s),
    .cap_status(cap_status), .cap_count(cap_count), .word(pf_word),
    .rx_len(rx_len), .rx_err(rx_err), .rx_mcast(rx_mcast)
  );
endmodule

// File: rtl/pdp_port_chk.sv
module pdp_port_chk #(
  parameter int OFS_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [1:0]       host_sel,
  input logic             host_byte,
  input logic             dwr,
  input logic             drd,
  input logic             ainc,
  input logic             rd_bit,
  input logic [OFS_W-1:0] ofs_q,
  input logic             mem_we,
  input logic             mem_re,
  input logic [1:0]       mem_be
);
  p_adv_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr || drd) && ainc && !host_byte |=> ofs_q == OFS_W'($past(ofs_q) + OFS_W'(2)));

  p_adv_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr || drd) && ainc && host_byte |=> ofs_q == OFS_W'($past(ofs_q) + OFS_W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr || drd) && !ainc |=> $stable(ofs_q));

  p_no_write_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == 2'd2 && rd_bit |-> !mem_we);

  p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && host_byte |-> $countones(mem_be) == 1);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_prefetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drd && ainc |-> mem_re);
endmodule

bind pdp_port pdp_port_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .host_wr(host_wr), .host_sel(host_sel),
  .host_byte(host_byte), .dwr(dwr), .drd(drd), .ainc(mode_q.ainc),
  .rd_bit(mode_q.rd), .ofs_q(ofs_q), .mem_we(mem_we), .mem_re(mem_re),
  .mem_be(mem_be)
);

// File: tb/tb_pdp_port.sv
`timescale 1ns/1ps
module tb_pdp_port;
  localparam int PN_W  = 2;
  localparam int OFS_W = 11;
  localparam int AW    = PN_W + OFS_W - 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic [1:0]       host_sel;
  logic             host_wr, host_rd, host_byte;
  logic [15:0]      host_wdata, host_rdata;
  logic [PN_W-1:0]  rx_head_pkt;
  logic [AW-1:0]    mem_addr;
  logic             mem_re, mem_we;
  logic [1:0]       mem_be;
  logic [15:0]      mem_wdata, mem_rdata;
  logic [OFS_W-1:0] rx_len;
  logic             rx_err, rx_mcast;

  pdp_port #(.PN_W(PN_W), .OFS_W(OFS_W)) dut (.*);

  logic [15:0] mem    [DEPTH];
  logic [15:0] shadow [DEPTH];

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int idx(input int pkt, input int ofs);
    return ((pkt & 3) << (OFS_W - 1)) | ((ofs & 2047) >> 1);
  endfunction

  function automatic logic [15:0] exp_len(input logic [15:0] st, input logic [15:0] cnt);
    return 16'((int'(cnt & 16'h07FF) - 6 + int'(st[12])) & 2047);
  endfunction

  function automatic logic [15:0] byte_of(input logic [15:0] w, input int ofs);
    return (ofs & 1) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic acc(input logic [1:0] s, input logic w, input logic r, input logic b,
                     input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    host_sel = s; host_wr = w; host_rd = r; host_byte = b; host_wdata = d;
    #1 q = host_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; host_byte = 1'b0; host_sel = 2'd3; host_wdata = '0;
  endtask

  logic [15:0] q;

  task automatic wptr(input logic [15:0] v); acc(2'd0, 1'b1, 1'b0, 1'b0, v, q); endtask
  task automatic wpkt(input logic [15:0] v); acc(2'd1, 1'b1, 1'b0, 1'b0, v, q); endtask
  task automatic wdat(input logic b, input logic [15:0] v); acc(2'd2, 1'b1, 1'b0, b, v, q); endtask
  task automatic rdat(input logic b, output logic [15:0] v); acc(2'd2, 1'b0, 1'b1, b, 16'h0, v); endtask
  task automatic rreg(input logic [1:0] s, output logic [15:0] v);
    idle(); acc(s, 1'b0, 1'b1, 1'b0, 16'h0, v); idle();
  endtask

  // bench model of a data write into shadow
  task automatic model_wr(input int pkt, input int ofs, input logic b, input logic [15:0] v);
    int i;
    i = idx(pkt, ofs);
    if (!b) shadow[i] = v;
    else if (ofs & 1) shadow[i][15:8] = v[7:0];
    else shadow[i][7:0] = v[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, st, cnt;
    int seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 16'($urandom);
      shadow[i] = mem[i];
    end
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_byte = 0; host_sel = 2'd3;
    host_wdata = 0; rx_head_pkt = 2'd3;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rreg(2'd0, v); chk("R1 pointer after reset", v, 16'h0000);
    rreg(2'd1, v); chk("R1 tx packet after reset", v, 16'h0000);
    @(negedge clk); #1 chk("R1 memory idle after reset", {mem_we, mem_re}, 2'b00);
    rreg(2'd3, v); chk("R1 unused register", v, 16'h0000);
    // R1 layout, reserved bits
    wptr(16'hFFFF); rreg(2'd0, v); chk("R1 pointer layout", v, 16'hE7FF);

    // R2 R3 word writes with auto-advance
    wpkt(16'd1); wptr(16'h4010);
    for (int k = 0; k < 4; k++) begin
      v = 16'hA000 + 16'(k);
      wdat(1'b0, v); model_wr(1, 16'h10 + 2*k, 1'b0, v);
    end
    rreg(2'd0, v); chk("R3 word advance", v, 16'h4018);
    for (int k = 0; k < 4; k++) chk("R2 word write address", mem[idx(1, 16'h10 + 2*k)], shadow[idx(1, 16'h10 + 2*k)]);

    // R4 byte writes from odd offset
    wptr(16'h4021);
    wdat(1'b1, 16'h77A1); model_wr(1, 16'h21, 1'b1, 16'h00A1);
    wdat(1'b1, 16'h66B2); model_wr(1, 16'h22, 1'b1, 16'h00B2);
    wdat(1'b1, 16'h55C3); model_wr(1, 16'h23, 1'b1, 16'h00C3);
    rreg(2'd0, v); chk("R3 byte advance", v, 16'h4024);
    chk("R4 high lane byte", mem[idx(1, 16'h20)], shadow[idx(1, 16'h20)]);
    chk("R4 both lanes byte", mem[idx(1, 16'h22)], shadow[idx(1, 16'h22)]);

    // R3 no auto-advance
    wptr(16'h0030);
    wdat(1'b0, 16'h1111); wdat(1'b0, 16'h2222); model_wr(1, 16'h30, 1'b0, 16'h2222);
    rreg(2'd0, v); chk("R3 hold without advance", v, 16'h0030);
    chk("R3 same address rewritten", mem[idx(1, 16'h30)], 16'h2222);

    // R5 back-to-back word reads straight after pointer write
    wptr(16'h6010);
    for (int k = 0; k < 4; k++) begin
      rdat(1'b0, v); chk("R5 consecutive word read", v, shadow[idx(1, 16'h10 + 2*k)]);
    end
    wptr(16'h6021);
    for (int k = 0; k < 3; k++) begin
      rdat(1'b1, v); chk("R4 R5 consecutive byte read", v, byte_of(shadow[idx(1, 16'h21 + k)], 16'h21 + k));
    end

    // R9 packet number change refetches
    wptr(16'h6040); wpkt(16'd2);
    rdat(1'b0, v); chk("R9 refetch after packet change", v, shadow[idx(2, 16'h40)]);

    // R2 receive area uses head packet input
    wpkt(16'd0); wptr(16'hE008);
    rdat(1'b0, v); chk("R2 receive area address", v, shadow[idx(3, 8)]);

    // R6 wrong direction
    wptr(16'h2050); wdat(1'b0, 16'hDEAD);
    rreg(2'd0, v); chk("R6 pointer held on ignored write", v, 16'h2050);
    chk("R6 no memory write in read mode", mem[idx(0, 16'h50)], shadow[idx(0, 16'h50)]);
    wptr(16'h4050); rdat(1'b0, v); chk("R6 read in write mode is zero", v, 16'h0000);
    rreg(2'd0, v); chk("R6 pointer held on ignored read", v, 16'h4050);

    // R3 wrap at the end of the offset range
    wpkt(16'd2); wptr(16'h47FF); wdat(1'b1, 16'h005A); model_wr(2, 16'h7FF, 1'b1, 16'h005A);
    rreg(2'd0, v); chk("R3 offset wrap", v, 16'h4000);
    chk("R4 wrap byte lane", mem[idx(2, 16'h7FF)], shadow[idx(2, 16'h7FF)]);

    // R7 R8 header decode
    for (int c = 0; c < 12; c++) begin
      case (c)
        0: begin st = 16'h0000; cnt = 16'h0040; end
        1: begin st = 16'h1000; cnt = 16'h0041; end
        2: begin st = 16'h8000; cnt = 16'hF840; end
        3: begin st = 16'h2000; cnt = 16'h0100; end
        4: begin st = 16'h0800; cnt = 16'h0006; end
        5: begin st = 16'h0400; cnt = 16'h0003; end
        6: begin st = 16'h0001; cnt = 16'h07FF; end
        default: begin st = 16'($urandom); cnt = 16'($urandom); end
      endcase
      mem[idx(3, 0)] = st;  shadow[idx(3, 0)] = st;
      mem[idx(3, 2)] = cnt; shadow[idx(3, 2)] = cnt;
      wptr(16'hE000);
      rdat(1'b0, v); chk("R7 status word read", v, st);
      rdat(1'b0, v); chk("R7 count word read", v, cnt);
      idle(); #1;
      chk("R7 payload length", 16'(rx_len), exp_len(st, cnt));
      chk("R8 error summary", rx_err, st[15] | st[13] | st[11] | st[10]);
      chk("R8 multicast flag", rx_mcast, st[0]);
    end

    // random runs: write then read back
    for (int it = 0; it < 150; it++) begin
      int pkt, ofs0, n, o;
      logic b;
      pkt  = int'($urandom_range(0, 3));
      ofs0 = int'($urandom_range(0, 2047));
      n    = int'($urandom_range(1, 8));
      b    = 1'($urandom_range(0, 1));
      wpkt(16'(pkt)); wptr(16'h4000 | 16'(ofs0));
      o = ofs0;
      for (int k = 0; k < n; k++) begin
        v = 16'($urandom);
        wdat(b, v); model_wr(pkt, o, b, v);
        o = (o + (b ? 1 : 2)) & 2047;
      end
      rreg(2'd0, v); chk("R3 random final pointer", v, 16'h4000 | 16'(o));
      wptr(16'h6000 | 16'(ofs0));
      o = ofs0;
      for (int k = 0; k < n; k++) begin
        rdat(b, v);
        chk("R5 random read back", v, b ? byte_of(shadow[idx(pkt, o)], o) : shadow[idx(pkt, o)]);
        o = (o + (b ? 1 : 2)) & 2047;
      end
    end
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule